// File: doc/BRIEF.md
# Reflected CRC-8 Byte Checker

This block keeps a running 8-bit checksum over a stream of received bytes from a single-wire sensor bus. Each byte presented with a valid strobe is folded into the checksum. The checksum polynomial is x^8+x^5+x^4+1, processed least-significant bit first, and the running value starts at zero. A frame is checked by feeding every byte of the frame, including the checksum byte the sender appended. When the frame is intact, the running value then returns to zero.

A clear input starts a new frame. A parameter selects between two implementations. One folds a whole byte in a single cycle. The other works bit-serially over eight cycles and reports this with a busy output. A good-frame flag rises when the residue is zero after at least one byte has been absorbed. This makes an 8-byte identity code, or a 9-byte scratchpad frame, readable as pass or fail once its last byte has been processed.

Top module: `crc8_rx_check`

## Requirements
- R1: After reset, crc_out is 0x00, frame_ok is 0 and busy is 0.
- R2: A byte d updates the checksum c to f(c XOR d). Here f applies eight steps to its argument v, and each step gives (v>>1) XOR 0x8C when bit 0 of v is 1, and v>>1 otherwise. From a zero checksum, f gives 0x5E for byte 0x01, 0xBC for byte 0x02 and 0x35 for byte 0xFF.
- R3: With SERIAL=0, a strobed byte is reflected in crc_out from the clock edge that samples the strobe, and busy stays 0.
- R4: With SERIAL=1, busy rises on the edge that samples a strobe and stays high for exactly 8 cycles. crc_out holds the updated checksum once busy falls.
- R5: With SERIAL=1, a byte strobe that arrives while busy is 1 is ignored and does not change the result.
- R6: frame_ok is 1 exactly when at least one byte has been accepted since the last reset or clear, crc_out is 0x00 and busy is 0.
- R7: Seven identity bytes followed by their checksum byte leave crc_out at 0x00 with frame_ok at 1. A corrupted checksum byte leaves frame_ok at 0.
- R8: Eight scratchpad bytes followed by their checksum byte, fed in order, leave frame_ok at 1.
- R9: clr sets crc_out to 0x00, frame_ok to 0 and busy to 0 on the next edge. It takes priority over a byte strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Start a new frame: checksum back to zero |
| byte_vld | input | 1 | Strobe: byte_in holds a byte to absorb |
| byte_in | input | 8 | Received byte |
| crc_out | output | 8 | Running checksum |
| busy | output | 1 | Serial variant is still shifting a byte |
| frame_ok | output | 1 | Zero residue after at least one byte |

## Verification
The hardest situation to reach is in the serial variant. There, a second strobe arrives partway through the eight shift cycles of an earlier byte, and a clear coincides with a strobe. The bench drives the two variants side by side with separate strobes. This lets it pulse a stray byte into the serial instance alone while that instance is busy. It then confirms that the finished checksum matches the single byte. Frames built by appending the bench's own checksum show the zero residue, and a flipped checksum bit shows the failing case.

// File: rtl/crc8_rx_check.sv
module crc8_rx_check #(
  parameter logic [7:0] POLY   = 8'h8C,
  parameter bit         SERIAL = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       byte_vld,
  input  logic [7:0] byte_in,
  output logic [7:0] crc_out,
  output logic       busy,
  output logic       frame_ok
);
  localparam int BITS = 8;
  localparam int CNT_W = $clog2(BITS + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BITS);

  logic [7:0] crc_q;
  logic       seen_q;

  function automatic logic [7:0] shift1(input logic [7:0] v);
    return v[0] ? ((v >> 1) ^ POLY) : (v >> 1);
  endfunction

  function automatic logic [7:0] fold8(input logic [7:0] v);
    logic [7:0] t;
    t = v;
    for (int i = 0; i < BITS; i++) t = shift1(t);
    return t;
  endfunction

  generate
    if (SERIAL) begin : g_ser
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          crc_q <= '0;
          cnt_q <= '0;
        end else if (clr) begin
          crc_q <= '0;
          cnt_q <= '0;
        end else if (cnt_q != '0) begin
          crc_q <= shift1(crc_q);
          cnt_q <= cnt_q - 1'b1;
        end else if (byte_vld) begin
          crc_q <= crc_q ^ byte_in;
          cnt_q <= CNT_LOAD;
        end
      end
      assign busy = (cnt_q != '0);
    end else begin : g_par
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        crc_q <= '0;
        else if (clr)      crc_q <= '0;
        else if (byte_vld) crc_q <= fold8(crc_q ^ byte_in);
      end
      assign busy = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 seen_q <= 1'b0;
    else if (clr)               seen_q <= 1'b0;
    else if (byte_vld && !busy) seen_q <= 1'b1;
  end

  assign crc_out  = crc_q;
  assign frame_ok = seen_q && (crc_q == 8'h00) && !busy;
endmodule

// File: rtl/crc8_rx_check_sva.sv
module crc8_rx_check_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       clr,
  input logic       byte_vld,
  input logic [7:0] crc_out,
  input logic       busy,
  input logic       frame_ok
);
  logic [3:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= '0;
    else if (busy) run_q <= run_q + 4'd1;
    else           run_q <= '0;
  end

  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (crc_out == 8'h00 && !frame_ok && !busy)); // R9
  AST_OK_RESIDUE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |-> (crc_out == 8'h00 && !busy)); // R6
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !byte_vld && !busy) |=> $stable(crc_out)); // R3
  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_q < 4'd8)); // R4
  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(byte_vld)); // R4
  AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && run_q == 4'd7) |=> !busy); // R4
endmodule

bind crc8_rx_check crc8_rx_check_sva u_sva (
  .clk(clk), .rst_n(rst_n), .clr(clr), .byte_vld(byte_vld),
  .crc_out(crc_out), .busy(busy), .frame_ok(frame_ok)
);

// File: tb/sim_crc8_rx_check.sv
module sim_crc8_rx_check;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic vld0 = 1'b0;
  logic vld1 = 1'b0;
  logic [7:0] din = 8'h00;
  logic [7:0] crc0, crc1;
  logic busy0, busy1, ok0, ok1;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  typedef struct packed {
    logic       inst;
    logic       ok;
    logic [7:0] crc;
    logic [7:0] req;
  } item_t;
  item_t sb[$];

  logic [7:0] mcrc = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  crc8_rx_check #(.SERIAL(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .byte_vld(vld0), .byte_in(din),
    .crc_out(crc0), .busy(busy0), .frame_ok(ok0));
  crc8_rx_check #(.SERIAL(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .byte_vld(vld1), .byte_in(din),
    .crc_out(crc1), .busy(busy1), .frame_ok(ok1));

  function automatic logic [7:0] spec_f(input logic [7:0] v);
    logic [7:0] t;
    t = v;
    for (int i = 0; i < 8; i++) t = t[0] ? ((t >> 1) ^ 8'h8C) : (t >> 1);
    return t;
  endfunction

  task automatic check(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [7:0] c;
      logic o;
      it = sb.pop_front();
      c = it.inst ? crc1 : crc0;
      o = it.inst ? ok1 : ok0;
      check(c == it.crc, $sformatf("R%0d crc u%0d", it.req, it.inst), c, it.crc);
      check(o == it.ok, $sformatf("R%0d ok u%0d", it.req, it.inst), o, it.ok);
    end
  end

  task automatic push_both(input logic [7:0] req, input bit seen);
    sb.push_back('{inst: 1'b0, ok: seen && (mcrc == 8'h00), crc: mcrc, req: req});
    sb.push_back('{inst: 1'b1, ok: seen && (mcrc == 8'h00), crc: mcrc, req: req});
  endtask

  task automatic send(input logic [7:0] d, input logic [7:0] req);
    @(negedge clk);
    din = d; vld0 = 1'b1; vld1 = 1'b1;
    @(negedge clk);
    vld0 = 1'b0; vld1 = 1'b0;
    while (busy1) @(negedge clk);
    mcrc = spec_f(mcrc ^ d);
    push_both(req, 1'b1);
  endtask

  task automatic clear_frame();
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    mcrc = 8'h00;
    push_both(8'd9, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] idb [8];
    logic [7:0] spb [9];
    int blen;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(crc0 == 8'h00 && crc1 == 8'h00, "R1 crc", {crc1, crc0}, 0);
    check(!ok0 && !ok1, "R1 ok", {ok1, ok0}, 0);
    check(!busy0 && !busy1, "R1 busy", {busy1, busy0}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 known values from zero
    send(8'h01, 8'd2);
    @(negedge clk);
    check(crc0 == 8'h5E, "R2 f(01)", crc0, 8'h5E);
    clear_frame();
    send(8'h02, 8'd2);
    @(negedge clk);
    check(crc0 == 8'hBC, "R2 f(02)", crc0, 8'hBC);
    clear_frame();
    send(8'hFF, 8'd2);
    @(negedge clk);
    check(crc1 == 8'h35, "R2 f(FF)", crc1, 8'h35);

    // R3 single-cycle variant: visible at first negedge after strobe edge
    clear_frame();
    @(negedge clk);
    din = 8'hA7; vld0 = 1'b1;
    @(negedge clk);
    vld0 = 1'b0;
    check(crc0 == spec_f(8'hA7), "R3 one-cycle", crc0, spec_f(8'hA7));
    check(!busy0, "R3 busy low", busy0, 0);

    // R4 serial busy length
    clear_frame();
    @(negedge clk);
    din = 8'h3C; vld1 = 1'b1;
    @(negedge clk);
    vld1 = 1'b0;
    blen = 0;
    while (busy1 && blen < 20) begin
      blen++;
      @(negedge clk);
    end
    check(blen == 8, "R4 busy length", blen, 8);
    check(crc1 == spec_f(8'h3C), "R4 serial result", crc1, spec_f(8'h3C));

    // R5 stray strobe while busy ignored
    clear_frame();
    @(negedge clk);
    din = 8'h01; vld1 = 1'b1;
    @(negedge clk);
    vld1 = 1'b0;
    repeat (3) @(negedge clk);
    din = 8'hFF; vld1 = 1'b1;
    @(negedge clk);
    vld1 = 1'b0;
    while (busy1) @(negedge clk);
    @(negedge clk);
    check(crc1 == 8'h5E, "R5 stray ignored", crc1, 8'h5E);
    check(!busy1, "R5 idle after", busy1, 0);

    // R7 identity frame
    clear_frame();
    idb = '{8'h28, 8'h3A, 8'h11, 8'h07, 8'h00, 8'h00, 8'h00, 8'h00};
    begin
      logic [7:0] c;
      c = 8'h00;
      for (int i = 0; i < 7; i++) c = spec_f(c ^ idb[i]);
      idb[7] = c;
    end
    for (int i = 0; i < 8; i++) send(idb[i], 8'd7);
    @(negedge clk);
    check(ok0 && ok1, "R7 id frame good", {ok1, ok0}, 3);

    // R7 corrupted checksum byte
    clear_frame();
    for (int i = 0; i < 7; i++) send(idb[i], 8'd7);
    send(idb[7] ^ 8'h04, 8'd7);
    @(negedge clk);
    check(!ok0 && !ok1, "R7 corrupt rejected", {ok1, ok0}, 0);

    // R8 scratchpad frame
    clear_frame();
    spb = '{8'h91, 8'h01, 8'h4B, 8'h46, 8'h7F, 8'hFF, 8'h0F, 8'h10, 8'h00};
    begin
      logic [7:0] c;
      c = 8'h00;
      for (int i = 0; i < 8; i++) c = spec_f(c ^ spb[i]);
      spb[8] = c;
    end
    for (int i = 0; i < 9; i++) send(spb[i], 8'd8);
    @(negedge clk);
    check(ok0 && ok1, "R8 scratchpad good", {ok1, ok0}, 3);

    // R6 no flag before any byte even though residue is zero
    clear_frame();
    @(negedge clk);
    check(crc0 == 8'h00 && !ok0 && !ok1, "R6 no byte no flag", {ok1, ok0}, 0);

    // R9 clear wins over simultaneous strobe
    send(8'h55, 8'd2);
    @(negedge clk);
    clr = 1'b1; din = 8'h99; vld0 = 1'b1; vld1 = 1'b1;
    @(negedge clk);
    clr = 1'b0; vld0 = 1'b0; vld1 = 1'b0;
    check(crc0 == 8'h00 && crc1 == 8'h00, "R9 clear priority crc", {crc1, crc0}, 0);
    check(!busy1 && !ok0 && !ok1, "R9 clear priority flags", {busy1, ok1, ok0}, 0);
    mcrc = 8'h00;

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule